// File: doc/BRIEF.md
# Data-Keyed Fractional Modulus Controller

This block produces the modulus-control line for a dual-modulus (divide by N or N+1) prescaler in a frequency synthesizer. A small loadable up-counter, clocked by the reference clock, runs from a start word up to all-ones and then reloads. The counter's least significant bit is the modulus-control output. Over one counter cycle, that bit is low for a fixed number of states. The resulting duty cycle adds a fraction to the average divide ratio.

Two start words are provided, one for the space tone and one for the mark tone. A single serial data bit chooses between them, and the choice is sampled only on the edge where the counter wraps. Each data level therefore maps to its own average divide ratio and so to its own output frequency. A constant data level holds its tone for any number of cycles, so the keying stays accurate down to DC. A one-clock strobe marks the first state of every counter cycle.

Top module: `fsk_modulus_ctrl`

## Requirements
- R1: While `rst` is high, each clock edge loads `space_word_i` into the counter and marks a new cycle. In the first state after `rst` falls, `cyc_start_o` is 1 and `mod_ctl_o` equals bit 0 of `space_word_i`.
- R2: When the counter is not at all-ones, each clock edge increments it by exactly one.
- R3: `tc_o` is 1 exactly in the states where the counter holds all-ones.
- R4: On the edge that leaves the all-ones state, the counter loads `mark_word_i` if `data_i` is 1, or `space_word_i` if `data_i` is 0. A cycle started from word s therefore lasts 2^W − s states.
- R5: `mod_ctl_o` is bit 0 of the counter. In a cycle started from odd word s, it is low for (2^W − s − 1)/2 states. With W = 4, s = 5 gives 11 states with 5 low, and s = 7 gives 9 states with 4 low.
- R6: `cyc_start_o` is 1 for exactly the first state of each cycle, which is the state just after a reload or a reset edge. It is 0 in every other state.
- R7: `data_i` and both load words are ignored on every edge that is not a wrap. Toggling `data_i` inside a cycle leaves that cycle's length and low count unchanged.
- R8: Load words must be odd, so that the low-state count is an integer. A load word of all-ones gives a one-state cycle, in which `mod_ctl_o` stays high and `cyc_start_o` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | 1 | Serial data bit: 1 selects the mark word, 0 selects the space word |
| space_word_i | input | W | Start word for the space tone |
| mark_word_i | input | W | Start word for the mark tone |
| mod_ctl_o | output | 1 | Modulus-control output, the counter LSB |
| tc_o | output | 1 | Counter is at all-ones |
| cyc_start_o | output | 1 | First state of a counter cycle |

## Verification
The main function is tried with these input patterns:
- Both data levels against several pairs of load words. This separates the choice of word from the word's value, and confirms the cycle length and the low count for each word.
- The word 13, which gives a three-state cycle, and the all-ones word, which gives a one-state cycle. Both test the wrap logic at its shortest.
- A cycle in which `data_i` toggles on every clock. This shows that only the level present at the wrap edge matters.
- A reset held while the words change. This shows that the space word is reloaded on every reset edge.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;

    typedef enum logic {
        TONE_SPACE = 1'b0,
        TONE_MARK  = 1'b1
    } tone_e;

endpackage

// File: rtl/fsk_reload_sel.sv
module fsk_reload_sel
    import fsk_mod_pkg::*;
#(
    parameter int W = 4
) (
    input  logic         data_i,
    input  logic [W-1:0] space_word_i,
    input  logic [W-1:0] mark_word_i,
    output logic [W-1:0] word_o
);

    tone_e tone;

    always_comb begin
        tone   = data_i ? TONE_MARK : TONE_SPACE;
        word_o = (tone == TONE_MARK) ? mark_word_i : space_word_i;
    end

endmodule

// File: rtl/fsk_cycle_counter.sv
module fsk_cycle_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] reload_word_i,
    input  logic [W-1:0] space_word_i,
    output logic [W-1:0] cnt_o,
    output logic         tc_o,
    output logic         start_o
);

    localparam logic [W-1:0] CNT_ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic         start;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       tc;

    assign tc = &st_q.cnt;

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        if (rst) begin
            st_d.cnt   = space_word_i;
            st_d.start = 1'b1;
        end else if (tc) begin
            st_d.cnt   = reload_word_i;
            st_d.start = 1'b1;
        end else begin
            st_d.cnt   = st_q.cnt + CNT_ONE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign cnt_o   = st_q.cnt;
    assign tc_o    = tc;
    assign start_o = st_q.start;

    AST_RST_LOAD: assert property (@(posedge clk)
        rst |=> (st_q.cnt == $past(space_word_i)) && st_q.start); // R1

    AST_COUNT_UP: assert property (@(posedge clk) disable iff (rst)
        !tc |=> st_q.cnt == W'($past(st_q.cnt) + CNT_ONE)); // R2

    AST_RELOAD_WORD: assert property (@(posedge clk) disable iff (rst)
        tc |=> st_q.cnt == $past(reload_word_i)); // R4

    AST_START_AFTER_WRAP: assert property (@(posedge clk) disable iff (rst)
        tc |=> st_q.start); // R6

    AST_NO_MID_START: assert property (@(posedge clk) disable iff (rst)
        !tc |=> !st_q.start); // R6

    AST_ODD_LOAD: assert property (@(posedge clk) disable iff (rst)
        tc |-> reload_word_i[0]); // R8

endmodule

// File: rtl/fsk_modulus_ctrl.sv
module fsk_modulus_ctrl #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         data_i,
    input  logic [W-1:0] space_word_i,
    input  logic [W-1:0] mark_word_i,
    output logic         mod_ctl_o,
    output logic         tc_o,
    output logic         cyc_start_o
);

    logic [W-1:0] reload_word;
    logic [W-1:0] cnt;

    fsk_reload_sel #(.W(W)) u_sel (
        .data_i       (data_i),
        .space_word_i (space_word_i),
        .mark_word_i  (mark_word_i),
        .word_o       (reload_word)
    );

    fsk_cycle_counter #(.W(W)) u_cnt (
        .clk           (clk),
        .rst           (rst),
        .reload_word_i (reload_word),
        .space_word_i  (space_word_i),
        .cnt_o         (cnt),
        .tc_o          (tc_o),
        .start_o       (cyc_start_o)
    );

    assign mod_ctl_o = cnt[0];

    AST_TC_ONLY_HIGH: assert property (@(posedge clk) disable iff (rst)
        tc_o |-> mod_ctl_o); // R3

endmodule

// File: tb/test_fsk_modulus_ctrl.sv
module test_fsk_modulus_ctrl;

    localparam int W = 4;
    localparam logic [W-1:0] ALL1 = '1;

    typedef struct packed {
        logic         data;
        logic [W-1:0] space;
        logic [W-1:0] mark;
        logic [7:0]   len;
        logic [7:0]   low;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 4'd5,  4'd7,  8'd11, 8'd5},
        '{1'b1, 4'd5,  4'd7,  8'd9,  8'd4},
        '{1'b0, 4'd1,  4'd3,  8'd15, 8'd7},
        '{1'b1, 4'd1,  4'd3,  8'd13, 8'd6},
        '{1'b1, 4'd13, 4'd15, 8'd1,  8'd0},
        '{1'b0, 4'd13, 4'd15, 8'd3,  8'd1},
        '{1'b1, 4'd9,  4'd11, 8'd5,  8'd2}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         data_i = 1'b0;
    logic [W-1:0] space_word_i = 4'd5;
    logic [W-1:0] mark_word_i = 4'd7;
    logic         mod_ctl_o, tc_o, cyc_start_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [W-1:0] m_cnt = '0;
    logic         m_start = 1'b0;

    always #10 clk = ~clk;

    fsk_modulus_ctrl #(.W(W)) i_fsk_modulus_ctrl (
        .clk          (clk),
        .rst          (rst),
        .data_i       (data_i),
        .space_word_i (space_word_i),
        .mark_word_i  (mark_word_i),
        .mod_ctl_o    (mod_ctl_o),
        .tc_o         (tc_o),
        .cyc_start_o  (cyc_start_o)
    );

    task automatic check(input logic ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // One clock: model the edge from the inputs held since the last negedge,
    // then compare the outputs at the following negedge.
    task automatic step();
        @(posedge clk);
        if (rst) begin
            m_cnt = space_word_i; m_start = 1'b1;
        end else if (m_cnt == ALL1) begin
            m_cnt = data_i ? mark_word_i : space_word_i; m_start = 1'b1;
        end else begin
            m_cnt = m_cnt + 1'b1; m_start = 1'b0;
        end
        @(negedge clk);
        check(mod_ctl_o == m_cnt[0], "R5 mod_ctl_o", int'(mod_ctl_o), int'(m_cnt[0]));
        check(tc_o == (m_cnt == ALL1), "R3 tc_o", int'(tc_o), int'(m_cnt == ALL1));
        check(cyc_start_o == m_start, "R6 cyc_start_o", int'(cyc_start_o), int'(m_start));
    endtask

    task automatic measure(input logic toggle, output int len, output int low);
        int guard = 0;
        while (!cyc_start_o && guard < 40) begin
            step();
            guard++;
        end
        len = 0;
        low = 0;
        do begin
            len++;
            if (!mod_ctl_o) low++;
            if (toggle) data_i = ~data_i;
            step();
        end while (!cyc_start_o && len < 40);
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int len, low;
        @(negedge clk);
        // R1: reset reloads space word on every edge, even as it changes
        space_word_i = 4'd9;
        step();
        space_word_i = 4'd11;
        step();
        check(cyc_start_o == 1'b1, "R1 start in reset", int'(cyc_start_o), 1);
        check(mod_ctl_o == 1'b1, "R1 mod in reset", int'(mod_ctl_o), 1);
        rst = 1'b0;
        step();
        step();
        check(cyc_start_o == 1'b0, "R2 no start after first state", int'(cyc_start_o), 0);
        check(mod_ctl_o == 1'b1, "R2 count 11->13 lsb", int'(mod_ctl_o), 1);

        // Table walk: R4 length, R5 low count, R8 all-ones word
        for (int i = 0; i < NV; i++) begin
            data_i = VECS[i].data;
            space_word_i = VECS[i].space;
            mark_word_i = VECS[i].mark;
            measure(1'b0, len, low); // first cycle may have started with old words
            measure(1'b0, len, low);
            check(len == int'(VECS[i].len), "R4 cycle length", len, int'(VECS[i].len));
            check(low == int'(VECS[i].low), "R5 low states", low, int'(VECS[i].low));
        end

        // R8: all-ones word keeps mod high and start high every clock
        data_i = 1'b1; space_word_i = 4'd5; mark_word_i = 4'd15;
        measure(1'b0, len, low);
        for (int k = 0; k < 5; k++) begin
            step();
            check(mod_ctl_o && cyc_start_o, "R8 one-state cycle", int'({mod_ctl_o, cyc_start_o}), 3);
        end

        // R7: toggling data inside a space cycle leaves it at 11 states, 5 low
        data_i = 1'b0; mark_word_i = 4'd7;
        measure(1'b0, len, low);
        measure(1'b0, len, low);
        data_i = 1'b0;
        measure(1'b1, len, low);
        check(len == 11, "R7 length under toggling", len, 11);
        check(low == 5, "R7 low count under toggling", low, 5);

        // R1: mid-cycle reset restarts from space word
        data_i = 1'b1;
        step(); step();
        rst = 1'b1;
        step();
        rst = 1'b0;
        check(cyc_start_o == 1'b1, "R1 restart strobe", int'(cyc_start_o), 1);
        measure(1'b0, len, low);
        check(len == 11, "R1 first cycle from space word", len, 11);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule